// File: doc/BRIEF.md
# Masked Interrupt Aggregation Register

This block collects fault flags from four source groups (supply, I/O, CAN, and temperature/low-power) and drives one active-low interrupt line. Each of five raw fault conditions is caught on its rising edge and held in a flag. A flag is released only after two things have happened: the host has acknowledged the source group's own status register, and the condition has been sampled low again. A 4-bit mask, written through a small register port at address 7, selects which groups may pull the interrupt line low. A read at the same address returns the held flags. In the mask, one bit covers two unrelated sources: high-side over-temperature and secondary regulator low. On read-back that bit shows only the over-temperature flag, so a host that sees the line low with that bit read as 0 can tell the regulator was the cause.

While the system is in stop mode, a rising edge on either of two over-current wake inputs produces a fixed-length low pulse on the interrupt line. This pulse leaves every readable flag untouched. Each of the two resets (power-on and external) clears the mask and all flags.

Top module: `irq_mask_aggregator`

## Requirements
- R1: After either reset, every status bit reads 0, the mask is 0 and irq_n is 1.
- R2: A write with wr_en=1 and addr=7 loads wdata into the mask at the next clock edge. A write to any other address leaves the mask, and therefore irq_n, unchanged.
- R3: With rd_en=1 and addr=7, rdata is the following status bits: bit3 supply low (src_fault[4]), bit2 high-side over-temperature (src_fault[2]), bit1 temperature pre-warning (src_fault[1]), bit0 CAN failure (src_fault[0]). In every other cycle rdata is 0.
- R4: A rising edge on any src_fault bit sets that source's flag at the next clock edge, whatever the mask holds.
- R5: A flag stays set while its fault input is still high, even if the group acknowledge pulses. The group acknowledge bits are grp_ack[0] CAN, [1] temperature, [2] I/O (sources 2 and 3), [3] supply. Once acknowledged, the flag clears at the first edge where the fault was already sampled low. The acknowledge can come in that same cycle or at any earlier point since the flag was last set.
- R6: If a rising fault edge arrives in the same cycle as a clear, the flag stays set. Any earlier acknowledge is then forgotten, so the flag needs a fresh acknowledge.
- R7: irq_n is 0 exactly when some mask bit is 1 and its group flag is set, or when the wake pulse is active. Mask bit 0 covers CAN, bit 1 temperature, bit 2 sources 2 or 3, and bit 3 supply.
- R8: Mask bit 2 lets either high-side over-temperature (src_fault[2]) or secondary regulator low (src_fault[3]) assert the interrupt. Read-back bit 2 shows only the over-temperature flag.
- R9: A rising edge of (wake_oc_a | wake_oc_b) while in_stop=1 holds irq_n at 0 for exactly 8 cycles and sets no status bit. The same edge while in_stop=0 has no effect.
- R10: Asserting ext_rst_n=0 alone clears the mask, so a later fault sets its flag but does not pull irq_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| addr | input | 3 | Register address |
| wdata | input | 4 | Write data (mask) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 4 | Read data (status) |
| src_fault | input | 5 | Raw fault conditions, bit order as in R3/R8 |
| grp_ack | input | 4 | One-cycle acknowledge per source group |
| in_stop | input | 1 | System is in stop mode |
| wake_oc_a | input | 1 | Over-current wake event A |
| wake_oc_b | input | 1 | Over-current wake event B |
| irq_n | output | 1 | Interrupt, active low |

## Verification
There are two pairs of functions that can land in the same cycle. The first pair is a flag clear and a fresh rising fault edge on the same source. The bench provokes this by holding a flag with its fault already sampled low, then driving the group acknowledge and a new fault rise together. It judges the result by reading the flag back several cycles later, with no further acknowledge, and requiring it to still be set. The second pair is the wake pulse and the masked flag path, which both drive irq_n. Every cycle, the bench compares irq_n and rdata against a behavioural model, so any overlap of the two shows up at once.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 4;
    localparam int NUM_SRC  = 5;
    localparam int NUM_GRP  = 4;
    localparam logic [ADDR_W-1:0] REG_ADDR = 3'b111;

    localparam int SRC_CAN   = 0;
    localparam int SRC_TEMP  = 1;
    localparam int SRC_HSOT  = 2;
    localparam int SRC_V2LOW = 3;
    localparam int SRC_VSUP  = 4;

    // acknowledge group that owns each source
    function automatic int src_group(input int s);
        case (s)
            SRC_CAN:   return 0;
            SRC_TEMP:  return 1;
            SRC_HSOT:  return 2;
            SRC_V2LOW: return 2;
            default:   return 3;
        endcase
    endfunction

    typedef struct packed {
        logic pend;
        logic seen;
        logic cq;
    } flag_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] mask;
    } reg_state_t;
endpackage

// File: rtl/flag_latch.sv
module flag_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic ack,
    output logic flag
);
    import irq_agg_pkg::*;

    flag_state_t st_d, st_q;

    always_comb begin
        logic ackv, rise, clr;
        st_d    = st_q;
        ackv    = ack | st_q.seen;
        rise    = raw & ~st_q.cq;
        clr     = st_q.pend & ackv & ~st_q.cq;
        st_d.pend = rise | (st_q.pend & ~clr);
        st_d.seen = st_d.pend & ackv & ~rise & ~clr;
        st_d.cq   = raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.pend;
endmodule

// File: rtl/wake_pulse.sv
module wake_pulse #(
    parameter int WAKE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_stop,
    input  logic ev_a,
    input  logic ev_b,
    output logic active
);
    localparam int CNT_W = $clog2(WAKE_CYC + 1);

    typedef struct packed {
        logic             ev_prev;
        logic [CNT_W-1:0] cnt;
    } wake_state_t;

    wake_state_t w_d, w_q;

    always_comb begin
        logic ev;
        w_d = w_q;
        ev  = in_stop & (ev_a | ev_b);
        if (ev && !w_q.ev_prev)  w_d.cnt = CNT_W'(WAKE_CYC);
        else if (w_q.cnt != '0)  w_d.cnt = w_q.cnt - 1'b1;
        w_d.ev_prev = ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign active = (w_q.cnt != '0);
endmodule

// File: rtl/irq_mask_aggregator.sv
module irq_mask_aggregator #(
    parameter int WAKE_CYC = 8
) (
    input  logic                           clk,
    input  logic                           por_n,
    input  logic                           ext_rst_n,
    input  logic [irq_agg_pkg::ADDR_W-1:0] addr,
    input  logic [irq_agg_pkg::DATA_W-1:0] wdata,
    input  logic                           wr_en,
    input  logic                           rd_en,
    output logic [irq_agg_pkg::DATA_W-1:0] rdata,
    input  logic [irq_agg_pkg::NUM_SRC-1:0] src_fault,
    input  logic [irq_agg_pkg::NUM_GRP-1:0] grp_ack,
    input  logic                           in_stop,
    input  logic                           wake_oc_a,
    input  logic                           wake_oc_b,
    output logic                           irq_n
);
    import irq_agg_pkg::*;

    logic               rst_n;
    logic [NUM_SRC-1:0] src_pend;
    logic [DATA_W-1:0]  grp_req;
    logic [DATA_W-1:0]  status;
    logic               wake_active;
    reg_state_t         r_d, r_q;
    logic [DATA_W-1:0]  mask_q;

    assign rst_n = por_n & ext_rst_n;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        flag_latch u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (src_fault[s]),
            .ack  (grp_ack[src_group(s)]),
            .flag (src_pend[s])
        );
    end

    wake_pulse #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_stop(in_stop),
        .ev_a   (wake_oc_a),
        .ev_b   (wake_oc_b),
        .active (wake_active)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en && addr == REG_ADDR) r_d.mask = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mask_q  = r_q.mask;
    assign grp_req = {src_pend[SRC_VSUP], src_pend[SRC_HSOT] | src_pend[SRC_V2LOW],
                      src_pend[SRC_TEMP], src_pend[SRC_CAN]};
    assign status  = {src_pend[SRC_VSUP], src_pend[SRC_HSOT],
                      src_pend[SRC_TEMP], src_pend[SRC_CAN]};
    assign rdata   = (rd_en && addr == REG_ADDR) ? status : '0;
    assign irq_n   = ~((|(mask_q & grp_req)) | wake_active);
endmodule

// File: rtl/irq_mask_aggregator_chk.sv
module irq_mask_aggregator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] addr,
    input logic [3:0] wdata,
    input logic       wr_en,
    input logic       rd_en,
    input logic [3:0] rdata,
    input logic [4:0] src_fault,
    input logic [4:0] src_pend,
    input logic [3:0] mask_q,
    input logic       wake_active,
    input logic       irq_n
);
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'b111) |=> (mask_q == $past(wdata))); // R2
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 3'b111) |=> $stable(mask_q)); // R2
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr == 3'b111) |-> (rdata == 4'b0000)); // R3
    AST_D2_HSOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'b111 && !src_pend[2]) |-> !rdata[2]); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (src_pend == 5'b0 && !wake_active) |-> irq_n); // R7
    AST_WAKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wake_active |-> !irq_n); // R9

    for (genvar s = 0; s < 5; s++) begin : g_chk
        AST_RISE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (src_fault[s] && !src_pend[s] && !$past(src_fault[s])) |=> src_pend[s]); // R4
        AST_HOLD_RAW: assert property (@(posedge clk) disable iff (!rst_n)
            (src_pend[s] && src_fault[s]) |=> src_pend[s]); // R5
    end
endmodule

bind irq_mask_aggregator irq_mask_aggregator_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wdata      (wdata),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rdata      (rdata),
    .src_fault  (src_fault),
    .src_pend   (src_pend),
    .mask_q     (mask_q),
    .wake_active(wake_active),
    .irq_n      (irq_n)
);

// File: tb/irq_mask_aggregator_tb.sv
module irq_mask_aggregator_tb;
    logic       clk = 0;
    logic       por_n, ext_rst_n;
    logic [2:0] addr;
    logic [3:0] wdata;
    logic       wr_en, rd_en;
    logic [3:0] rdata;
    logic [4:0] src_fault;
    logic [3:0] grp_ack;
    logic       in_stop, wake_oc_a, wake_oc_b;
    logic       irq_n;

    int tests = 0;
    int fails = 0;

    // behavioural model state
    int m_mask;
    int m_pend[5], m_seen[5], m_cq[5];
    int m_wprev, m_wcnt;

    always #10 clk = ~clk;

    irq_mask_aggregator u_dut (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .addr(addr),
        .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .src_fault(src_fault), .grp_ack(grp_ack), .in_stop(in_stop),
        .wake_oc_a(wake_oc_a), .wake_oc_b(wake_oc_b), .irq_n(irq_n)
    );

    function automatic int grp_of(int s);
        if (s == 0) return 0;
        if (s == 1) return 1;
        if (s == 4) return 3;
        return 2;
    endfunction

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mask = 0; m_wprev = 0; m_wcnt = 0;
        for (int s = 0; s < 5; s++) begin m_pend[s] = 0; m_seen[s] = 0; m_cq[s] = 0; end
    endtask

    task automatic tick();
        int req, sts, e_irq, e_rd;
        #1;
        if (!por_n || !ext_rst_n) model_reset();
        req = (m_pend[4] << 3) | ((m_pend[2] | m_pend[3]) << 2) | (m_pend[1] << 1) | m_pend[0];
        sts = (m_pend[4] << 3) | (m_pend[2] << 2) | (m_pend[1] << 1) | m_pend[0];
        e_irq = ((m_mask & req) != 0 || m_wcnt > 0) ? 0 : 1;
        e_rd  = (rd_en && addr == 3'd7) ? sts : 0;
        chk("MODEL irq_n R7", {3'b0, irq_n}, 4'(e_irq));
        chk("MODEL rdata R3", rdata, 4'(e_rd));
        @(posedge clk);
        if (por_n && ext_rst_n) begin
            for (int s = 0; s < 5; s++) begin
                int ackv, rise, clr, np;
                ackv = grp_ack[grp_of(s)] | m_seen[s];
                rise = src_fault[s] & ~m_cq[s] & 1;
                clr  = m_pend[s] & ackv & (m_cq[s] ? 0 : 1);
                np   = (rise || (m_pend[s] && !clr)) ? 1 : 0;
                m_seen[s] = (np && ackv && !rise && !clr) ? 1 : 0;
                m_pend[s] = np;
                m_cq[s]   = src_fault[s];
            end
            if (wr_en && addr == 3'd7) m_mask = wdata;
            begin
                int ev;
                ev = in_stop & (wake_oc_a | wake_oc_b);
                if (ev && !m_wprev) m_wcnt = 8;
                else if (m_wcnt > 0) m_wcnt--;
                m_wprev = ev;
            end
        end
        @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [3:0] d);
        addr = a; wdata = d; wr_en = 1; tick(); wr_en = 0; addr = 0;
    endtask

    task automatic rd(output logic [3:0] v);
        addr = 3'd7; rd_en = 1; #1 v = rdata; tick(); rd_en = 0; addr = 0;
    endtask

    task automatic ack(int g);
        grp_ack = 4'(1 << g); tick(); grp_ack = 0;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [3:0] v;
        int lows;
        por_n = 0; ext_rst_n = 1; addr = 0; wdata = 0; wr_en = 0; rd_en = 0;
        src_fault = 0; grp_ack = 0; in_stop = 0; wake_oc_a = 0; wake_oc_b = 0;
        model_reset();
        @(negedge clk);
        repeat (3) tick();
        por_n = 1; tick();

        chk("R1 irq_n after reset", {3'b0, irq_n}, 4'h1);
        rd(v); chk("R1 status after reset", v, 4'h0);

        wr(3'd3, 4'hF);
        src_fault[0] = 1; tick(); tick();
        chk("R2 write to other address ignored", {3'b0, irq_n}, 4'h1);
        rd(v); chk("R4 flag set with mask 0", v, 4'h1);
        wr(3'd7, 4'h1);
        chk("R7 masked CAN asserts irq", {3'b0, irq_n}, 4'h0);

        ack(0); tick();
        rd(v); chk("R5 held while raw high", v, 4'h1);
        src_fault[0] = 0; tick(); tick(); tick();
        rd(v); chk("R5 cleared after earlier ack", v, 4'h0);
        chk("R7 irq released", {3'b0, irq_n}, 4'h1);

        src_fault[0] = 1; tick();
        src_fault[0] = 0; tick(); tick();
        grp_ack = 4'h1; src_fault[0] = 1; tick();
        grp_ack = 0; src_fault[0] = 0; tick(); tick(); tick();
        rd(v); chk("R6 rise beats clear", v, 4'h1);
        ack(0); tick();
        rd(v); chk("R6 fresh ack clears", v, 4'h0);

        wr(3'd7, 4'h4);
        src_fault[3] = 1; tick(); tick();
        chk("R8 secondary low via mask bit2", {3'b0, irq_n}, 4'h0);
        rd(v); chk("R8 D2 hides secondary low", v, 4'h0);
        src_fault[3] = 0; tick(); ack(2); tick();
        chk("R8 secondary low cleared", {3'b0, irq_n}, 4'h1);
        src_fault[2] = 1; tick(); tick();
        rd(v); chk("R8 D2 shows over-temperature", v, 4'h4);
        chk("R8 over-temperature irq", {3'b0, irq_n}, 4'h0);
        src_fault[2] = 0; tick(); ack(2); tick();
        rd(v); chk("R5 I/O group cleared", v, 4'h0);

        wr(3'd7, 4'h0);
        wake_oc_a = 1; tick(); wake_oc_a = 0; tick();
        chk("R9 wake outside stop ignored", {3'b0, irq_n}, 4'h1);
        in_stop = 1; wake_oc_b = 1;
        lows = 0;
        for (int i = 0; i < 12; i++) begin
            tick();
            if (irq_n === 1'b0) lows++;
        end
        chk("R9 wake pulse length", 4'(lows), 4'd8);
        rd(v); chk("R9 wake sets no status", v, 4'h0);
        wake_oc_b = 0; in_stop = 0; tick();

        wr(3'd7, 4'hF);
        src_fault[1] = 1; tick(); tick();
        chk("R10 temp irq before ext reset", {3'b0, irq_n}, 4'h0);
        ext_rst_n = 0; tick(); ext_rst_n = 1; tick(); tick();
        chk("R10 mask cleared by ext reset", {3'b0, irq_n}, 4'h1);
        rd(v); chk("R10 fault relatched after reset", v, 4'h2);
        src_fault[1] = 0; tick(); ack(1); tick();
        rd(v); chk("R5 temp group cleared", v, 4'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule